// File: doc/BRIEF.md
# Two-Level Chained Bus Arbiter

This block decides which device may drive a shared bus. Devices are sorted into two priority tiers, high and low. Each tier has one request line and one grant line toward the central arbiter. The arbiter sees only the OR of the requests inside a tier, so it learns that a tier wants the bus but not which member asked. The arbiter raises the grant line of the winning tier. That grant then runs down the tier's chain from device 0 onward. The first requesting device it meets keeps it, and every device that is not requesting lets it pass.

The chain of each tier is modelled inside the block as a ripple through the per-device request vector. The registered result appears on one grant output per device. The owner keeps the bus for as long as it holds its request, and no later request can take the bus from it, whatever its tier. When the owner lets go, the bus falls idle for one cycle and arbitration then runs again over the requests present at that edge. The block also drives a busy flag and the number of the tier that holds the bus.

Top module: `busarb_top`

## Requirements
- R1: While reset is asserted, every grant output, `busy` and `ownerLevel` are 0, even with all requests raised.
- R2: When no grant is active and at least one request is sampled at a rising edge, a grant is visible right after that edge. This includes the first edge after reset is released.
- R3: Inside the winning tier, the grant goes to the lowest-numbered requesting device (bit 0 sits nearest the arbiter). Only that one grant bit is set.
- R4: If both tiers have requests when arbitration takes place, the high tier (`hiReq`/`hiGnt`) wins and the low tier gets nothing.
- R5: Across `hiGnt` and `loGnt` together, at most one bit is set in any cycle.
- R6: While the owning device keeps its request asserted, all grant outputs stay unchanged, even if other devices of either tier raise requests.
- R7: When the owner's request is sampled low at an edge, every grant is clear after that edge. The next edge then grants from the requests present there.
- R8: `busy` is 1 exactly when a grant is active. `ownerLevel` is 1 when a low-tier device owns the bus and 0 otherwise, including when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiReq | input | DEVICES | Requests of the high-priority tier, bit 0 nearest the arbiter |
| loReq | input | DEVICES | Requests of the low-priority tier, bit 0 nearest the arbiter |
| hiGnt | output | DEVICES | Per-device grants of the high tier |
| loGnt | output | DEVICES | Per-device grants of the low tier |
| busy | output | 1 | Some device owns the bus |
| ownerLevel | output | 1 | Tier of the owner: 0 high, 1 low |

## Verification
The bound checker watches, on every cycle:
- that grants are exclusive;
- that an idle bus with requests pending is always granted at the next edge, with the high tier taking it whenever it asks;
- that a held request freezes the grants;
- that a dropped owner frees the bus one edge later;
- that the busy and tier outputs agree with the grants.

Which device inside a chain wins is shown by the bench. It sweeps every combination of the two request vectors from idle and works out the winner as the lowest set bit. Several scenarios can only be seen as a sequence over many cycles, and directed bench scenarios cover them:
- the refusal to preempt a low-tier owner;
- the single idle cycle between owners;
- the hand-over inside one chain and from the high tier to the low tier.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  localparam int LEVELS = 2;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  typedef struct packed {
    logic doLoad;
    logic doFree;
  } arbStrobe_t;
endpackage

// File: rtl/busarb_chain.sv
module busarb_chain #(
  parameter int DEVICES = 4
) (
  input  logic               grantIn,
  input  logic [DEVICES-1:0] req,
  output logic [DEVICES-1:0] gnt
);
  // Grant ripples from device 0; a requester absorbs it, others pass it on.
  always_comb begin
    logic open;
    open = grantIn;
    for (int i = 0; i < DEVICES; i++) begin
      gnt[i] = open & req[i];
      open   = open & ~req[i];
    end
  end
endmodule

// File: rtl/busarb_dp.sv
module busarb_dp
  import busarb_pkg::*;
#(
  parameter int DEVICES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [LEVELS-1:0][DEVICES-1:0]  reqV,
  input  arbStrobe_t                      strobe,
  output logic [LEVELS-1:0][DEVICES-1:0]  gntV,
  output logic [LVL_W-1:0]                ownerLvl,
  output logic                            anyReq,
  output logic                            ownerHeld
);
  logic [LEVELS-1:0]               lvlAny;
  logic [LEVELS-1:0]               lvlLine;
  logic [LEVELS-1:0][DEVICES-1:0]  candV;
  logic [LEVELS-1:0][DEVICES-1:0]  gntQ;
  logic [LVL_W-1:0]                winLvl;
  logic [LVL_W-1:0]                ownerQ;

  // One summary line and one chain per tier; tier 0 has top priority.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign lvlAny[l] = |reqV[l];
    if (l == 0) begin : g_top
      assign lvlLine[l] = lvlAny[l];
    end else begin : g_lower
      assign lvlLine[l] = lvlAny[l] & ~(|lvlAny[l-1:0]);
    end
    busarb_chain #(.DEVICES(DEVICES)) u_chain (
      .grantIn (lvlLine[l]),
      .req     (reqV[l]),
      .gnt     (candV[l])
    );
  end

  always_comb begin
    winLvl = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (lvlAny[l]) winLvl = LVL_W'(l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntQ   <= '0;
      ownerQ <= '0;
    end else if (strobe.doFree) begin
      gntQ   <= '0;
      ownerQ <= '0;
    end else if (strobe.doLoad) begin
      gntQ   <= candV;
      ownerQ <= winLvl;
    end
  end

  assign anyReq    = |lvlAny;
  assign ownerHeld = |(gntQ & reqV);
  assign gntV      = gntQ;
  assign ownerLvl  = ownerQ;
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerHeld,
  output arbStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_HELD} arbState_t;
  arbState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (anyReq) begin
        strobe.doLoad = 1'b1;
        stateNext     = ST_HELD;
      end
      ST_HELD: if (!ownerHeld) begin
        strobe.doFree = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
#(
  parameter int DEVICES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEVICES-1:0] hiReq,
  input  logic [DEVICES-1:0] loReq,
  output logic [DEVICES-1:0] hiGnt,
  output logic [DEVICES-1:0] loGnt,
  output logic               busy,
  output logic [LVL_W-1:0]   ownerLevel
);
  logic [LEVELS-1:0][DEVICES-1:0] reqV;
  logic [LEVELS-1:0][DEVICES-1:0] gntV;
  arbStrobe_t                     strobe;
  logic                           anyReq;
  logic                           ownerHeld;

  assign reqV[0] = hiReq;
  assign reqV[1] = loReq;

  busarb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .ownerHeld (ownerHeld),
    .strobe    (strobe)
  );

  busarb_dp #(.DEVICES(DEVICES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqV      (reqV),
    .strobe    (strobe),
    .gntV      (gntV),
    .ownerLvl  (ownerLevel),
    .anyReq    (anyReq),
    .ownerHeld (ownerHeld)
  );

  assign hiGnt = gntV[0];
  assign loGnt = gntV[1];
  assign busy  = |gntV;
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
  parameter int DEVICES = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [DEVICES-1:0] hiReq,
  input logic [DEVICES-1:0] loReq,
  input logic [DEVICES-1:0] hiGnt,
  input logic [DEVICES-1:0] loGnt,
  input logic               busy,
  input logic               ownerLevel
);
  logic held;
  assign held = (|(hiGnt & hiReq)) || (|(loGnt & loReq));

  assert_onehot_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hiGnt, loGnt}));

  assert_idle_grants_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ((|hiReq) || (|loReq))) |=> busy);

  assert_high_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (|hiReq)) |=> ((|hiGnt) && (loGnt == '0)));

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rstN)
    held |=> ($stable(hiGnt) && $stable(loGnt)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !held) |=> !busy);

  assert_low_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
    ownerLevel |-> ((|loGnt) && (hiGnt == '0)));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ownerLevel && (hiGnt == '0) && (loGnt == '0)));
endmodule

bind busarb_top busarb_chk #(.DEVICES(DEVICES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hiReq      (hiReq),
  .loReq      (loReq),
  .hiGnt      (hiGnt),
  .loGnt      (loGnt),
  .busy       (busy),
  .ownerLevel (ownerLevel)
);

// File: tb/busarb_top_tb.sv
module busarb_top_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] hiReq, loReq, hiGnt, loGnt;
  logic         busy;
  logic         ownerLevel;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  busarb_top #(.DEVICES(N)) u_dut (
    .clk(clk), .rstN(rstN), .hiReq(hiReq), .loReq(loReq),
    .hiGnt(hiGnt), .loGnt(loGnt), .busy(busy), .ownerLevel(ownerLevel)
  );

  // Compare the full output set against {level, busy, loGnt, hiGnt}.
  task automatic expectOut(input string tag, input logic [N-1:0] eHi, input logic [N-1:0] eLo);
    logic [2*N+1:0] act, exp;
    act = {ownerLevel, busy, loGnt, hiGnt};
    exp = {(eLo != '0), ((eHi != '0) || (eLo != '0)), eLo, eHi};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] h, input logic [N-1:0] l);
    hiReq = h;
    loReq = l;
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  initial begin
    rstN  = 1'b0;
    hiReq = '1;
    loReq = '1;
    repeat (3) @(negedge clk);
    expectOut("R1 reset holds grants low", '0, '0);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R2 first edge after reset", 4'b0001, '0);
    drive('0, '0);
    expectOut("R7 release after reset grant", '0, '0);

    // R3 R4 R2: full sweep from idle.
    for (int v = 0; v < 256; v++) begin
      logic [N-1:0] h, l, eH, eL;
      h  = v[3:0];
      l  = v[7:4];
      eH = lowest(h);
      eL = (h != '0) ? '0 : lowest(l);
      drive(h, l);
      expectOut("R3 R4 sweep winner", eH, eL);
      drive('0, '0);
      expectOut("R7 sweep release", '0, '0);
    end

    // R6: low-tier owner is not preempted by high-tier requests.
    drive('0, 4'b0100);
    expectOut("R8 low tier owner", '0, 4'b0100);
    for (int k = 0; k < 3; k++) begin
      drive(4'b0001, 4'b0110);
      expectOut("R6 no preemption", '0, 4'b0100);
    end
    drive(4'b0001, 4'b0010);
    expectOut("R7 idle gap after drop", '0, '0);
    @(negedge clk);
    expectOut("R7 rearbitration high wins", 4'b0001, '0);

    // Hand-over inside the high chain.
    drive(4'b1011, 4'b0011);
    expectOut("R6 owner kept", 4'b0001, '0);
    drive(4'b1010, 4'b0011);
    expectOut("R7 idle gap in chain", '0, '0);
    @(negedge clk);
    expectOut("R3 next in chain", 4'b0010, '0);
    drive(4'b1000, 4'b0011);
    expectOut("R7 idle gap", '0, '0);
    @(negedge clk);
    expectOut("R3 far device", 4'b1000, '0);

    // High tier lets go, low tier takes over.
    drive('0, 4'b0011);
    expectOut("R7 idle before low", '0, '0);
    @(negedge clk);
    expectOut("R8 low tier level", '0, 4'b0001);
    drive('0, '0);
    expectOut("R8 idle level zero", '0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule